// File: doc/BRIEF.md
# Operand Hazard Interlock Unit

This block decides, every cycle, whether the micro-op sitting in the issue/address-generation stage (AG) of an in-order pipeline may advance into the execute stage (EX). It keeps a short age-ordered record of the destination registers written by the micro-ops issued in the last three cycles. Each record entry also notes whether that result is ready at the end of EX or only one stage later, at the load-completion stage. Load data, including every word of a multi-word load, is ready at the later stage. ALU, multiply, multiply-accumulate, base-register updates and address outputs are ready at EX.

The incoming micro-op presents up to two source registers. Each source is tagged as needed either at AG (base addresses of loads, stores and multi-word accesses) or at EX (ALU, multiply, divide, branch conditions, multiply-accumulate operands and store data). For each source, the unit reports which in-flight producer the value must be forwarded from. It raises a stall while any source is still too young to be forwarded. A stalled micro-op stays in AG and a bubble enters EX.

The required issue distance is one cycle. One cycle is added if the producer is ready at the late stage, and one more if the operand is needed at AG. This gives 3 cycles for a load feeding an address, 2 for a load feeding EX, 2 for an EX-ready result feeding an address, and 1 for an EX-ready result feeding EX.

Top module: `hzl_interlock`

## Requirements
- R1: After reset, and after a reset applied while producers are in flight, no producer is tracked: `stall` is 0 and every forward code is 0 for any consumer.
- R2: The forward code of a used source of a valid micro-op is the age in cycles (1, 2 or 3) of the youngest tracked producer of that register. Code 0 means the register file. Codes are 2 bits each; source 0 is at `fwd_sel[1:0]` and source 1 is at `fwd_sel[3:2]`.
- R3: `stall` is 1 exactly when some used source has a nonzero forward code below its required distance. The required distance is 1, plus 1 if the producer is late-ready, plus 1 if the operand is needed at AG. An AG operand is therefore never issued with code 1.
- R4: A load result used as an address stalls for two cycles after an adjacent issue and is then forwarded with code 3.
- R5: A load result used at EX stalls for one cycle and is then forwarded with code 2.
- R6: An EX-ready result used as an address needs distance 2. The same result used at EX never stalls and is forwarded with code 1.
- R7: Each word micro-op of a multi-word load is tracked on its own. The second-to-last word is usable as an address two cycles after the last word's micro-op issues; the last word needs three cycles.
- R8: The need stage is per source. An accumulator operand or store data marked as needed at EX follows the EX rule even when the other source of the same micro-op is needed at AG.
- R9: Register 0 is never a hazard. A source of 0 always gets code 0, and a producer writing register 0 is not tracked.
- R10: When several tracked producers write the same register, only the youngest decides both the stall and the forward code.
- R11: A stalled micro-op, and a cycle with `iss_valid` low, enter no producer into tracking. The record still ages by one stage.
- R12: With `iss_valid` low, `stall` and every forward code are 0.
- R13: Destination kind encoding in `iss_dst_kind`: 0 means no result, 1 means ready at EX, and 2 or 3 means ready at the load-completion stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A micro-op is present in AG |
| iss_src_reg | input | NSRC*RW | Source register numbers, source 0 in the low bits |
| iss_src_use | input | NSRC | Source is read by this micro-op |
| iss_src_at_ag | input | NSRC | 1: source needed at AG, 0: needed at EX |
| iss_dst_reg | input | RW | Destination register of this micro-op |
| iss_dst_kind | input | 2 | Result kind (see R13) |
| stall | output | 1 | Hold AG and send a bubble into EX |
| fwd_sel | output | NSRC*2 | Per-source forward code (see R2) |

## Verification
The bench runs a continuous micro-op stream. It aims at the load-to-address case, where an off-by-one in the late-ready penalty would release the consumer after one stall cycle instead of two. It also covers the multi-word load, where treating the whole load as one producer would misjudge the second-to-last word. A same-register pair with the younger producer being a load catches a design that picks the oldest match: it would forward code 2 or 3 and miss the stall. A stalled micro-op that reads its own destination register exposes a design that lets the held micro-op enter tracking, because the next cycle would report code 1. Register 0, idle cycles and a reset taken mid-flight round out the corner cases.

// File: rtl/hzl_pkg.sv
package hzl_pkg;

    // Result-ready kind carried by each issuing micro-op
    typedef enum logic [1:0] {
        RDY_NONE  = 2'd0,
        RDY_EX    = 2'd1,
        RDY_LATE  = 2'd2,
        RDY_LATE2 = 2'd3
    } rdy_e;

    // Age window: base distance plus late-producer and address-stage penalties
    localparam int BASE_DIST = 1;
    localparam int TRACK_DEPTH = BASE_DIST + 1 + 1;

    function automatic int need_dist(input logic late, input logic at_ag);
        return BASE_DIST + int'(late) + int'(at_ag);
    endfunction

endpackage

// File: rtl/hzl_track.sv
module hzl_track
    import hzl_pkg::*;
#(
    parameter int RW    = 5,
    parameter int DEPTH = TRACK_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [RW-1:0]             push_reg,
    input  logic                      push_late,
    output logic [DEPTH-1:0]          trk_vld,
    output logic [DEPTH-1:0][RW-1:0]  trk_reg,
    output logic [DEPTH-1:0]          trk_late
);

    // Entry 0 is the producer issued one cycle ago (now in EX)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_vld[0]  <= 1'b0;
            trk_reg[0]  <= '0;
            trk_late[0] <= 1'b0;
        end else begin
            trk_vld[0]  <= push;
            trk_reg[0]  <= push ? push_reg : '0;
            trk_late[0] <= push & push_late;
        end
    end

    // Older entries age by one stage per cycle regardless of stalls
    for (genvar s = 1; s < DEPTH; s++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trk_vld[s]  <= 1'b0;
                trk_reg[s]  <= '0;
                trk_late[s] <= 1'b0;
            end else begin
                trk_vld[s]  <= trk_vld[s-1];
                trk_reg[s]  <= trk_reg[s-1];
                trk_late[s] <= trk_late[s-1];
            end
        end
    end

endmodule

// File: rtl/hzl_src_cmp.sv
module hzl_src_cmp
    import hzl_pkg::*;
#(
    parameter int RW    = 5,
    parameter int DEPTH = TRACK_DEPTH,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      op_valid,
    input  logic                      src_use,
    input  logic [RW-1:0]             src_reg,
    input  logic                      src_at_ag,
    input  logic [DEPTH-1:0]          trk_vld,
    input  logic [DEPTH-1:0][RW-1:0]  trk_reg,
    input  logic [DEPTH-1:0]          trk_late,
    output logic [CW-1:0]             fwd_code,
    output logic                      hazard
);

    logic          live;
    logic          hit;
    logic          hit_late;
    logic [CW-1:0] hit_age;
    logic [CW-1:0] need;

    assign live = op_valid && src_use && (src_reg != '0);

    // Scan oldest to youngest so the youngest match wins
    always_comb begin
        hit      = 1'b0;
        hit_late = 1'b0;
        hit_age  = '0;
        for (int j = DEPTH - 1; j >= 0; j--) begin
            if (trk_vld[j] && (trk_reg[j] == src_reg)) begin
                hit      = 1'b1;
                hit_late = trk_late[j];
                hit_age  = CW'(j + 1);
            end
        end
    end

    assign need     = CW'(need_dist(hit_late, src_at_ag));
    assign fwd_code = (live && hit) ? hit_age : '0;
    assign hazard   = live && hit && (hit_age < need);

endmodule

// File: rtl/hzl_interlock.sv
module hzl_interlock
    import hzl_pkg::*;
#(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [NSRC*RW-1:0]        iss_src_reg,
    input  logic [NSRC-1:0]           iss_src_use,
    input  logic [NSRC-1:0]           iss_src_at_ag,
    input  logic [RW-1:0]             iss_dst_reg,
    input  logic [1:0]                iss_dst_kind,
    output logic                      stall,
    output logic [NSRC*2-1:0]         fwd_sel
);

    localparam int DEPTH = TRACK_DEPTH;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]          trk_vld;
    logic [DEPTH-1:0][RW-1:0]  trk_reg;
    logic [DEPTH-1:0]          trk_late;
    logic [NSRC-1:0]           src_haz;
    logic                      dst_writes;
    logic                      dst_late;
    logic                      push;

    // Decode the result kind of the issuing micro-op
    always_comb begin
        unique case (rdy_e'(iss_dst_kind))
            RDY_NONE: begin
                dst_writes = 1'b0;
                dst_late   = 1'b0;
            end
            RDY_EX: begin
                dst_writes = 1'b1;
                dst_late   = 1'b0;
            end
            default: begin
                dst_writes = 1'b1;
                dst_late   = 1'b1;
            end
        endcase
    end

    assign stall = iss_valid && (|src_haz);
    assign push  = iss_valid && !stall && dst_writes && (iss_dst_reg != '0);

    hzl_track #(.RW(RW), .DEPTH(DEPTH)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_reg  (iss_dst_reg),
        .push_late (dst_late),
        .trk_vld   (trk_vld),
        .trk_reg   (trk_reg),
        .trk_late  (trk_late)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [CW-1:0] code;
        hzl_src_cmp #(.RW(RW), .DEPTH(DEPTH), .CW(CW)) u_cmp (
            .op_valid  (iss_valid),
            .src_use   (iss_src_use[i]),
            .src_reg   (iss_src_reg[i*RW +: RW]),
            .src_at_ag (iss_src_at_ag[i]),
            .trk_vld   (trk_vld),
            .trk_reg   (trk_reg),
            .trk_late  (trk_late),
            .fwd_code  (code),
            .hazard    (src_haz[i])
        );
        assign fwd_sel[i*2 +: 2] = 2'(code);
    end

endmodule

// File: rtl/hzl_interlock_chk.sv
module hzl_interlock_chk #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [NSRC*RW-1:0]   iss_src_reg,
    input logic [NSRC-1:0]      iss_src_use,
    input logic [NSRC-1:0]      iss_src_at_ag,
    input logic [RW-1:0]        iss_dst_reg,
    input logic [1:0]           iss_dst_kind,
    input logic                 stall,
    input logic [NSRC*2-1:0]    fwd_sel,
    input logic                 ex_vld
);

    // Records whether a late-ready producer issued in the previous cycle
    logic          prev_ld;
    logic [RW-1:0] prev_ld_reg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ld     <= 1'b0;
            prev_ld_reg <= '0;
        end else begin
            prev_ld     <= iss_valid && !stall && iss_dst_kind[1] && (iss_dst_reg != '0);
            prev_ld_reg <= iss_dst_reg;
        end
    end

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (!stall && (fwd_sel == '0)));

    assert_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ex_vld);

    assert_zero_dst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && (iss_dst_reg == '0)) |=> !ex_vld);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_zero_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && (iss_src_reg[i*RW +: RW] == '0)) |-> (fwd_sel[i*2 +: 2] == 2'd0));

        assert_addr_dist_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && !stall && iss_src_use[i] && iss_src_at_ag[i])
                |-> (fwd_sel[i*2 +: 2] != 2'd1));

        assert_load_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_ld && iss_valid && iss_src_use[i] && iss_src_at_ag[i]
                && (iss_src_reg[i*RW +: RW] == prev_ld_reg)) |-> stall);
    end

endmodule

bind hzl_interlock hzl_interlock_chk #(.RW(RW), .NSRC(NSRC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .iss_valid     (iss_valid),
    .iss_src_reg   (iss_src_reg),
    .iss_src_use   (iss_src_use),
    .iss_src_at_ag (iss_src_at_ag),
    .iss_dst_reg   (iss_dst_reg),
    .iss_dst_kind  (iss_dst_kind),
    .stall         (stall),
    .fwd_sel       (fwd_sel),
    .ex_vld        (trk_vld[0])
);

// File: tb/tb_hzl_interlock.sv
module tb_hzl_interlock;

    localparam int RW   = 5;
    localparam int NSRC = 2;
    localparam int NV   = 30;

    typedef struct packed {
        logic       v;
        logic [4:0] a0; logic u0; logic g0;
        logic [4:0] a1; logic u1; logic g1;
        logic [4:0] d;  logic [1:0] k;
        logic       st; logic [1:0] f0; logic [1:0] f1;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(input int v, input int a0, input int u0, input int g0,
                                input int a1, input int u1, input int g1,
                                input int d, input int k, input int st,
                                input int f0, input int f1, input int rq);
        vec_t r;
        r.v = 1'(v); r.a0 = 5'(a0); r.u0 = 1'(u0); r.g0 = 1'(g0);
        r.a1 = 5'(a1); r.u1 = 1'(u1); r.g1 = 1'(g1);
        r.d = 5'(d); r.k = 2'(k); r.st = 1'(st);
        r.f0 = 2'(f0); r.f1 = 2'(f1); r.rq = 4'(rq);
        return r;
    endfunction

    // Kinds: 0 none, 1 EX-ready, 2 late-ready (R13). Codes: age 1..3, 0 regfile (R2).
    localparam vec_t VEC [0:NV-1] = '{
        mk(1, 1,1,1, 0,0,0,  5,2, 0,0,0, 2),  // R2 load r5, empty record
        mk(1, 5,1,0, 2,1,0,  6,1, 1,1,0, 5),  // R5 load->EX, age 1: stall
        mk(1, 5,1,0, 2,1,0,  6,1, 0,2,0, 5),  // R5 age 2: go
        mk(1, 6,1,1, 5,1,0,  0,0, 1,1,3, 6),  // R6 EX->addr age 1 stall; R8 data r5 age 3
        mk(1, 6,1,1, 5,1,0,  0,0, 0,2,0, 8),  // R6 R8 go
        mk(1, 6,1,1, 0,0,0,  8,2, 0,3,0, 2),  // R2 load r8
        mk(1, 8,1,1, 0,1,0,  9,1, 1,1,0, 4),  // R4 load->addr, R9 src r0
        mk(1, 8,1,1, 0,1,0,  9,1, 1,2,0, 4),  // R4 still stalled
        mk(1, 8,1,1, 0,1,0,  9,1, 0,3,0, 4),  // R4 go at age 3
        mk(1, 9,1,0, 0,0,0,  0,1, 0,1,0, 6),  // R6 EX->EX, dest r0
        mk(1, 0,1,1, 9,1,1,  0,0, 0,0,2, 9),  // R9 r0 untracked, r9 age 2
        mk(0, 9,1,1, 0,0,0,  9,2, 0,0,0, 12), // R12 idle cycle with a dest
        mk(1, 9,1,0, 0,0,0,  3,1, 0,0,0, 11), // R11 idle cycle left nothing
        mk(1, 1,1,1, 0,0,0,  3,2, 0,0,0, 2),  // R10 younger load on r3
        mk(1, 3,1,0, 4,1,0,  4,1, 1,1,0, 10), // R10 youngest is load: stall
        mk(1, 3,1,0, 4,1,0,  4,1, 0,2,0, 10), // R10 code 2; R11 held op not tracked
        mk(1, 0,0,0, 0,0,0, 10,2, 0,0,0, 2),  // R2 load r10
        mk(1, 0,0,0, 0,0,0, 10,1, 0,0,0, 6),  // R6 younger EX write r10
        mk(1,10,1,0, 4,1,1,  0,0, 0,1,3, 10), // R10 youngest EX wins, r4 age 3
        mk(1, 0,0,0, 0,0,0, 11,2, 0,0,0, 7),  // R7 word 1
        mk(1, 0,0,0, 0,0,0, 12,2, 0,0,0, 7),  // R7 word 2
        mk(1, 0,0,0, 0,0,0, 13,2, 0,0,0, 7),  // R7 last word
        mk(1,12,1,1,13,1,1,  0,0, 1,2,1, 7),  // R7 both too young
        mk(1,12,1,1,13,1,1,  0,0, 1,3,2, 7),  // R7 second-to-last ready, last not
        mk(1,12,1,1,13,1,1,  0,0, 0,0,3, 7),  // R7 last ready at 3
        mk(1, 1,1,1, 0,0,0, 20,2, 0,0,0, 2),  // R2 load r20
        mk(1,20,1,0, 0,0,0, 20,1, 1,1,0, 8),  // R8 accumulator at EX: stall
        mk(1,20,1,0, 0,0,0, 20,1, 0,2,0, 8),  // R8 go
        mk(1,20,1,1, 0,0,0,  0,0, 1,1,0, 10), // R10 young EX result as addr: R3 stall
        mk(1,20,1,1, 0,0,0,  0,0, 0,2,0, 3)   // R3 go at age 2
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 iss_valid;
    logic [NSRC*RW-1:0]   iss_src_reg;
    logic [NSRC-1:0]      iss_src_use;
    logic [NSRC-1:0]      iss_src_at_ag;
    logic [RW-1:0]        iss_dst_reg;
    logic [1:0]           iss_dst_kind;
    logic                 stall;
    logic [NSRC*2-1:0]    fwd_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hzl_interlock #(.RW(RW), .NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_reg(iss_src_reg), .iss_src_use(iss_src_use),
        .iss_src_at_ag(iss_src_at_ag), .iss_dst_reg(iss_dst_reg),
        .iss_dst_kind(iss_dst_kind), .stall(stall), .fwd_sel(fwd_sel)
    );

    task automatic apply(input vec_t t);
        iss_valid     = t.v;
        iss_src_reg   = {t.a1, t.a0};
        iss_src_use   = {t.u1, t.u0};
        iss_src_at_ag = {t.g1, t.g0};
        iss_dst_reg   = t.d;
        iss_dst_kind  = t.k;
    endtask

    task automatic check(input string tag, input logic est, input logic [3:0] efw);
        checks++;
        if (stall !== est) begin
            errors++;
            $display("FAIL %s stall: actual=%0b expected=%0b", tag, stall, est);
        end
        checks++;
        if (fwd_sel !== efw) begin
            errors++;
            $display("FAIL %s fwd_sel: actual=%h expected=%h", tag, fwd_sel, efw);
        end
    endtask

    initial begin
        apply(mk(0, 0,0,0, 0,0,0, 0,0, 0,0,0, 0));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh reset, consumer of r5 as an address sees nothing
        apply(mk(1, 5,1,1, 6,1,0, 0,0, 0,0,0, 1));
        #2 check("R1 reset state", 1'b0, 4'h0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            #2 check($sformatf("R%0d row %0d", VEC[i].rq, i), VEC[i].st, {VEC[i].f1, VEC[i].f0});
            @(negedge clk);
        end

        // R1: reset taken while a load is in flight clears tracking
        apply(mk(1, 0,0,0, 0,0,0, 5,2, 0,0,0, 1));
        @(negedge clk);
        apply(mk(0, 0,0,0, 0,0,0, 0,0, 0,0,0, 1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(mk(1, 5,1,1, 0,0,0, 0,0, 0,0,0, 1));
        #2 check("R1 mid-flight reset", 1'b0, 4'h0);
        @(negedge clk);

        // R13: kind 3 behaves as late-ready (two stalls for an address use)
        apply(mk(1, 0,0,0, 0,0,0, 7,3, 0,0,0, 13));
        @(negedge clk);
        apply(mk(1, 7,1,1, 0,0,0, 0,0, 0,0,0, 13));
        #2 check("R13 kind3 age1", 1'b1, 4'h1);
        @(negedge clk);
        #2 check("R13 kind3 age2", 1'b1, 4'h2);
        @(negedge clk);
        #2 check("R13 kind3 age3", 1'b0, 4'h3);
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule